// File: doc/BRIEF.md
# Eight-Bit CPU Effective Address Sequencer

This block forms the 16-bit effective address that an 8-bit accumulator machine needs before its data access. A one-cycle start pulse and a mode code begin the sequence. The block then pulls one or two operand bytes from an operand stream that uses a valid/ready handshake. For the indirect modes it also fetches a two-byte pointer, low byte first, over a simple byte-read port. It ends by presenting the address together with a one-cycle done strobe.

The index registers, the stack pointer, the direct-page register and the stack-width flag are plain inputs that the surrounding core holds steady. Direct-page addresses take their high byte from the page register instead of a fixed zero page. The stack-relative mode increments its pointer inside one page or across the whole space, depending on the stack-width flag. The block covers address generation only: it does not decode instructions and it does not perform the data access that follows.

Top module: `ea_seq`

## Requirements
- R1: While reset is held and once it is released, busy_o, done_o, mem_rd_o and opd_ready_o are all low.
- R2: An operand byte is taken only in a cycle where opd_valid_i and opd_ready_o are both high. Modes 0, 1, 2, 10 and 11 take two bytes (low first). Every other mode takes one byte. While opd_valid_i stays low the block waits with busy_o high and done_o low.
- R3: Absolute mode (code 0) gives {second byte, first byte}. Absolute-X (code 1) adds x_i to that value modulo 65536, and absolute-Y (code 2) adds y_i modulo 65536.
- R4: Direct mode (code 3) gives {bp_i, byte}. Direct-X (code 4) and direct-Y (code 5) add x_i or y_i to the low byte modulo 256, so the high byte stays bp_i.
- R5: Pre-indexed indirect (code 6) reads the pointer low byte at {bp_i, byte+x_i mod 256} and the high byte at the same page with the low byte incremented modulo 256. The result is {high, low}.
- R6: Post-indexed indirect (code 7 adds y_i, code 8 adds z_i) reads the pointer at {bp_i, byte} and then at {bp_i, byte+1 mod 256}. The result is the pointer plus the index, modulo 65536.
- R7: Stack-relative (code 9) reads the pointer low byte at {sp_i[15:8], sp_i[7:0]+byte mod 256}. When ext_stk_i is 1, the second read increments only the low address byte. When ext_stk_i is 0, it increments the full 16-bit address. A third dummy read then repeats the second address, and the result is the pointer plus y_i modulo 65536.
- R8: Absolute indirect (code 10) reads the target low byte at {second, first} and the high byte at that address plus one modulo 65536. The increment carries into the high byte.
- R9: Indexed indirect (code 11) first adds x_i to {second, first} modulo 65536 and then fetches the target as in R8.
- R10: mem_rd_o is high for one cycle per byte read, and mem_rdata_i is taken in the cycle that follows. Codes 0 to 5 issue no read.
- R11: busy_o rises in the cycle after an accepted start and stays high through the single-cycle done_o pulse. ea_o is valid with done_o and holds until the next done. start_i and mode_i are ignored while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a sequence (sampled while idle) |
| mode_i | input | 4 | Addressing mode code |
| x_i | input | 8 | X index |
| y_i | input | 8 | Y index |
| z_i | input | 8 | Z index |
| sp_i | input | 16 | Stack pointer |
| bp_i | input | 8 | Direct-page high byte |
| ext_stk_i | input | 1 | 1: stack pointer increments stay in one page |
| opd_valid_i | input | 1 | Operand byte available |
| opd_data_i | input | 8 | Operand byte |
| opd_ready_o | output | 1 | Block takes an operand byte |
| mem_rd_o | output | 1 | Byte read request |
| mem_addr_o | output | 16 | Read address |
| mem_rdata_i | input | 8 | Read data, valid the cycle after the request |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion strobe |
| ea_o | output | 16 | Effective address |

## Verification
A corrupted pointer register shows up on mem_addr_o at the very next read. The bench therefore logs every read address and compares the whole sequence, which exposes a wrong page wrap or a missing carry two cycles after the first pointer read. A wrong latched low byte or a wrong index choice appears only in ea_o, in the done cycle. A state machine that takes a wrong branch shows as an extra or missing operand byte, a read count that is off, or a done strobe that never arrives before the timeout.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [3:0] {
    AM_ABS    = 4'd0,
    AM_ABS_X  = 4'd1,
    AM_ABS_Y  = 4'd2,
    AM_DIR    = 4'd3,
    AM_DIR_X  = 4'd4,
    AM_DIR_Y  = 4'd5,
    AM_PRE_X  = 4'd6,
    AM_POST_Y = 4'd7,
    AM_POST_Z = 4'd8,
    AM_STK_Y  = 4'd9,
    AM_IND    = 4'd10,
    AM_IND_X  = 4'd11
  } am_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_OP_LO, ST_OP_HI, ST_RD_LO, ST_CAP_LO,
    ST_RD_HI, ST_CAP_HI, ST_DUMMY, ST_DUMMY_W, ST_DONE
  } st_e;

  function automatic logic am_two_byte(am_e m);
    return (m == AM_ABS) || (m == AM_ABS_X) || (m == AM_ABS_Y) ||
           (m == AM_IND) || (m == AM_IND_X);
  endfunction

  function automatic logic am_indirect(am_e m);
    return (m == AM_PRE_X) || (m == AM_POST_Y) || (m == AM_POST_Z) ||
           (m == AM_STK_Y) || (m == AM_IND) || (m == AM_IND_X);
  endfunction

endpackage

// File: rtl/agu_idx_add.sv
// Adds an unsigned index to a two-byte base; page_wrap_i suppresses the
// carry into the high byte.
module agu_idx_add #(
  parameter int DW = 8
) (
  input  logic [2*DW-1:0] base_i,
  input  logic [DW-1:0]   idx_i,
  input  logic            page_wrap_i,
  output logic [2*DW-1:0] sum_o
);
  logic [DW:0]   lo_sum;
  logic [DW-1:0] hi_sum;

  assign lo_sum = {1'b0, base_i[DW-1:0]} + {1'b0, idx_i};
  assign hi_sum = base_i[2*DW-1:DW] + DW'(lo_sum[DW] & ~page_wrap_i);
  assign sum_o  = {hi_sum, lo_sum[DW-1:0]};
endmodule

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import agu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  am_e  mode_q_i,
  input  logic opd_fire_i,
  output st_e  state_o
);
  st_e state_q, state_d;
  logic state_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_OP_LO;
      ST_OP_LO:   if (opd_fire_i) begin
                    if (am_two_byte(mode_q_i))      state_d = ST_OP_HI;
                    else if (am_indirect(mode_q_i)) state_d = ST_RD_LO;
                    else                            state_d = ST_DONE;
                  end
      ST_OP_HI:   if (opd_fire_i)
                    state_d = am_indirect(mode_q_i) ? ST_RD_LO : ST_DONE;
      ST_RD_LO:   state_d = ST_CAP_LO;
      ST_CAP_LO:  state_d = ST_RD_HI;
      ST_RD_HI:   state_d = ST_CAP_HI;
      ST_CAP_HI:  state_d = (mode_q_i == AM_STK_Y) ? ST_DUMMY : ST_DONE;
      ST_DUMMY:   state_d = ST_DUMMY_W;
      ST_DUMMY_W: state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  assign state_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= ST_IDLE;
    else if (state_en) state_q <= state_d;
  end

  assign state_o = state_q;

  p_start_leaves_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start_i) |=> (state_q == ST_OP_LO));
endmodule

// File: rtl/ea_seq.sv
module ea_seq
  import agu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [3:0]      mode_i,
  input  logic [DW-1:0]   x_i,
  input  logic [DW-1:0]   y_i,
  input  logic [DW-1:0]   z_i,
  input  logic [2*DW-1:0] sp_i,
  input  logic [DW-1:0]   bp_i,
  input  logic            ext_stk_i,
  input  logic            opd_valid_i,
  input  logic [DW-1:0]   opd_data_i,
  output logic            opd_ready_o,
  output logic            mem_rd_o,
  output logic [2*DW-1:0] mem_addr_o,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [2*DW-1:0] ea_o
);
  localparam int AW = 2 * DW;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  st_e state;
  am_e mode_q, mode_d, mode_dec;
  logic [DW-1:0] op_lo_q, op_lo_d, lo_q, lo_d;
  logic [AW-1:0] ptr_q, ptr_d, ea_q, ea_d;
  logic mode_en, op_lo_en, lo_en, ptr_en, ea_en;

  logic opd_fire, start_acc, last_opd;
  logic [AW-1:0] opd_base, opd_sum, ptr_step, fin_sum;
  logic [DW-1:0] opd_idx, fin_idx;
  logic opd_wrap, ptr_wrap;

  assign mode_dec  = (mode_i > 4'd11) ? AM_ABS : am_e'(mode_i);
  assign start_acc = (state == ST_IDLE) && start_i;
  assign opd_ready_o = (state == ST_OP_LO) || (state == ST_OP_HI);
  assign opd_fire  = opd_ready_o && opd_valid_i;
  assign last_opd  = opd_fire &&
                     ((state == ST_OP_HI) || !am_two_byte(mode_q));

  agu_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_i   (start_acc),
    .mode_q_i  (mode_q),
    .opd_fire_i(opd_fire),
    .state_o   (state)
  );

  // operand-stage address: direct page, stack, or two-byte absolute
  always_comb begin
    opd_base = {opd_data_i, op_lo_q};
    opd_idx  = '0;
    opd_wrap = 1'b0;
    unique case (mode_q)
      AM_DIR, AM_POST_Y, AM_POST_Z: begin
        opd_base = {bp_i, opd_data_i}; opd_wrap = 1'b1;
      end
      AM_DIR_X, AM_PRE_X: begin
        opd_base = {bp_i, opd_data_i}; opd_idx = x_i; opd_wrap = 1'b1;
      end
      AM_DIR_Y: begin
        opd_base = {bp_i, opd_data_i}; opd_idx = y_i; opd_wrap = 1'b1;
      end
      AM_STK_Y: begin
        opd_base = sp_i; opd_idx = opd_data_i; opd_wrap = 1'b1;
      end
      AM_ABS_X, AM_IND_X: opd_idx = x_i;
      AM_ABS_Y:           opd_idx = y_i;
      default: ;
    endcase
  end

  agu_idx_add #(.DW(DW)) u_opd_add (
    .base_i(opd_base), .idx_i(opd_idx), .page_wrap_i(opd_wrap), .sum_o(opd_sum)
  );

  // pointer high-byte address: wraps in page except where a carry is wanted
  assign ptr_wrap = (mode_q == AM_PRE_X) || (mode_q == AM_POST_Y) ||
                    (mode_q == AM_POST_Z) || ((mode_q == AM_STK_Y) && ext_stk_i);

  agu_idx_add #(.DW(DW)) u_ptr_inc (
    .base_i(ptr_q), .idx_i(DW'(1)), .page_wrap_i(ptr_wrap), .sum_o(ptr_step)
  );

  // post index on the fetched pointer, always across 16 bits
  always_comb begin
    unique case (mode_q)
      AM_POST_Y, AM_STK_Y: fin_idx = y_i;
      AM_POST_Z:           fin_idx = z_i;
      default:             fin_idx = '0;
    endcase
  end

  agu_idx_add #(.DW(DW)) u_fin_add (
    .base_i({mem_rdata_i, lo_q}), .idx_i(fin_idx), .page_wrap_i(1'b0), .sum_o(fin_sum)
  );

  // next-state for datapath registers
  always_comb begin
    mode_d   = mode_dec;
    mode_en  = start_acc;
    op_lo_d  = opd_data_i;
    op_lo_en = opd_fire && (state == ST_OP_LO);
    lo_d     = mem_rdata_i;
    lo_en    = (state == ST_CAP_LO);
    ptr_d    = ptr_step;
    ptr_en   = (state == ST_CAP_LO);
    ea_d     = fin_sum;
    ea_en    = (state == ST_CAP_HI);
    if (last_opd) begin
      if (am_indirect(mode_q)) begin
        ptr_d  = opd_sum;
        ptr_en = 1'b1;
      end else begin
        ea_d  = opd_sum;
        ea_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mode_q  <= AM_ABS;
      op_lo_q <= '0;
      lo_q    <= '0;
      ptr_q   <= '0;
      ea_q    <= '0;
    end else begin
      if (mode_en)  mode_q  <= mode_d;
      if (op_lo_en) op_lo_q <= op_lo_d;
      if (lo_en)    lo_q    <= lo_d;
      if (ptr_en)   ptr_q   <= ptr_d;
      if (ea_en)    ea_q    <= ea_d;
    end
  end

  assign mem_rd_o   = (state == ST_RD_LO) || (state == ST_RD_HI) || (state == ST_DUMMY);
  assign mem_addr_o = ptr_q;
  assign busy_o     = (state != ST_IDLE);
  assign done_o     = (state == ST_DONE);
  assign ea_o       = ea_q;

  // assertions
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_int_n |-> (!busy_o && !mem_rd_o && !opd_ready_o && !done_o));

  p_ready_busy_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    opd_ready_o |-> busy_o);

  p_page_wrap_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state == ST_RD_HI && ptr_wrap) |->
      (mem_addr_o[AW-1:DW] == $past(mem_addr_o[AW-1:DW], 2)));

  p_dummy_repeat_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state == ST_DUMMY) |-> (mem_addr_o == $past(mem_addr_o, 2)));

  p_full_carry_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state == ST_RD_HI && !ptr_wrap) |->
      (mem_addr_o == $past(mem_addr_o, 2) + AW'(1)));

  p_no_read_direct_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_rd_o |-> am_indirect(mode_q));

  p_done_busy_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |-> busy_o);

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |=> !done_o);

  p_ea_hold_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!busy_o && $past(!busy_o)) |-> $stable(ea_o));
endmodule

// File: tb/ea_seq_tb_top.sv
`timescale 1ns/1ps
module ea_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [3:0] mode;
  logic [7:0] x, y, z, bp;
  logic [15:0] sp;
  logic ext_stk;
  logic feed_en;
  logic [7:0] opd_data;
  logic opd_ready;
  logic mem_rd;
  logic [15:0] mem_addr;
  logic [7:0] mem_rdata;
  logic busy, done;
  logic [15:0] ea;

  int total = 0;
  int bad = 0;
  int opd_cnt = 0;
  int opd_base = 0;
  int rd_cnt = 0;
  logic [7:0] ob0, ob1;
  logic [15:0] rd_log [0:15];

  always #2 clk = ~clk;

  ea_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode),
    .x_i(x), .y_i(y), .z_i(z), .sp_i(sp), .bp_i(bp), .ext_stk_i(ext_stk),
    .opd_valid_i(feed_en), .opd_data_i(opd_data), .opd_ready_o(opd_ready),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .busy_o(busy), .done_o(done), .ea_o(ea)
  );

  function automatic logic [7:0] mv(input logic [15:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'hA5;
  endfunction

  assign opd_data = (opd_cnt == opd_base) ? ob0 : ob1;

  always @(posedge clk) begin
    if (feed_en && opd_ready) opd_cnt <= opd_cnt + 1;
    if (mem_rd) begin
      mem_rdata <= mv(mem_addr);
      rd_log[rd_cnt % 16] <= mem_addr;
      rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_done(input string req);
    bit got = 0;
    for (int i = 0; i < 40 && !got; i++) begin
      if (done) got = 1;
      else @(negedge clk);
    end
    chk({req, " R11 done seen"}, got, 1);
  endtask

  task automatic run_mode(input logic [3:0] m, input logic [7:0] b0, input logic [7:0] b1,
                          input int nbytes, input logic [15:0] exp_ea, input int nrd,
                          input logic [15:0] a0, input logic [15:0] a1,
                          input logic [15:0] a2, input string req);
    int rbase;
    logic [15:0] held;
    @(negedge clk);
    mode = m; ob0 = b0; ob1 = b1; opd_base = opd_cnt; rbase = rd_cnt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({req, " R11 busy after start"}, busy, 1);
    wait_done(req);
    chk({req, " ea"}, ea, exp_ea);
    chk({req, " R2 bytes taken"}, opd_cnt - opd_base, nbytes);
    chk({req, " R10 read count"}, rd_cnt - rbase, nrd);
    if (nrd > 0) chk({req, " R10 first read addr"}, rd_log[rbase % 16], a0);
    if (nrd > 1) chk({req, " second read addr"}, rd_log[(rbase + 1) % 16], a1);
    if (nrd > 2) chk({req, " dummy read addr"}, rd_log[(rbase + 2) % 16], a2);
    held = ea;
    @(negedge clk);
    chk({req, " R11 done one cycle"}, {done, busy}, 2'b00);
    chk({req, " R11 ea held"}, ea, held);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; start = 0; mode = 0; x = 0; y = 0; z = 0; bp = 0; sp = 0;
    ext_stk = 0; feed_en = 1; ob0 = 0; ob1 = 0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {busy, done, mem_rd, opd_ready}, 4'b0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after reset", {busy, done, mem_rd, opd_ready}, 4'b0000);
  endtask

  task automatic t_absolute;
    run_mode(4'd0, 8'h34, 8'h12, 2, 16'h1234, 0, 0, 0, 0, "R3 abs");
    x = 8'hF0;
    run_mode(4'd1, 8'h20, 8'h12, 2, 16'h1310, 0, 0, 0, 0, "R3 abs+x carry");
    y = 8'h02;
    run_mode(4'd2, 8'hFF, 8'hFF, 2, 16'h0001, 0, 0, 0, 0, "R3 abs+y wrap64k");
  endtask

  task automatic t_direct;
    bp = 8'h40; x = 8'h20; y = 8'hFF;
    run_mode(4'd3, 8'h80, 8'h00, 1, 16'h4080, 0, 0, 0, 0, "R4 direct");
    run_mode(4'd4, 8'hF0, 8'h00, 1, 16'h4010, 0, 0, 0, 0, "R4 direct+x page wrap");
    run_mode(4'd5, 8'h01, 8'h00, 1, 16'h4000, 0, 0, 0, 0, "R4 direct+y page wrap");
  endtask

  task automatic t_pre_indexed;
    bp = 8'h22; x = 8'h01;
    run_mode(4'd6, 8'hFE, 8'h00, 1, {mv(16'h2200), mv(16'h22FF)}, 2,
             16'h22FF, 16'h2200, 0, "R5 pre-indexed");
  endtask

  task automatic t_post_indexed;
    logic [15:0] p;
    bp = 8'h33; y = 8'hC0; z = 8'h7F;
    p = {mv(16'h3300), mv(16'h33FF)};
    run_mode(4'd7, 8'hFF, 8'h00, 1, p + 16'h00C0, 2, 16'h33FF, 16'h3300, 0, "R6 post y");
    run_mode(4'd8, 8'hFF, 8'h00, 1, p + 16'h007F, 2, 16'h33FF, 16'h3300, 0, "R6 post z");
  endtask

  task automatic t_stack;
    sp = 16'h15F0; y = 8'h90; ext_stk = 1'b1;
    run_mode(4'd9, 8'h0F, 8'h00, 1, {mv(16'h1500), mv(16'h15FF)} + 16'h0090, 3,
             16'h15FF, 16'h1500, 16'h1500, "R7 stack page wrap");
    ext_stk = 1'b0;
    run_mode(4'd9, 8'h0F, 8'h00, 1, {mv(16'h1600), mv(16'h15FF)} + 16'h0090, 3,
             16'h15FF, 16'h1600, 16'h1600, "R7 stack full carry");
  endtask

  task automatic t_indirect;
    run_mode(4'd10, 8'hFF, 8'h30, 2, {mv(16'h3100), mv(16'h30FF)}, 2,
             16'h30FF, 16'h3100, 0, "R8 indirect carry");
    x = 8'h00;
    run_mode(4'd11, 8'hFF, 8'hFF, 2, {mv(16'h0000), mv(16'hFFFF)}, 2,
             16'hFFFF, 16'h0000, 0, "R8 R9 top wrap");
    x = 8'h20;
    run_mode(4'd11, 8'hF0, 8'h30, 2, {mv(16'h3111), mv(16'h3110)}, 2,
             16'h3110, 16'h3111, 0, "R9 indexed indirect");
  endtask

  task automatic t_stall_restart;
    bit got = 0;
    bp = 8'h51;
    @(negedge clk);
    feed_en = 1'b0; mode = 4'd3; ob0 = 8'h77; ob1 = 8'h99; opd_base = opd_cnt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    mode = 4'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 stall busy/done", {busy, done}, 2'b10);
    chk("R2 stall no byte taken", opd_cnt - opd_base, 0);
    feed_en = 1'b1;
    wait_done("R11 restart ignored");
    chk("R11 mode kept over restart", ea, 16'h5177);
    chk("R2 one byte after stall", opd_cnt - opd_base, 1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (done) got = 1;
    end
    chk("R11 no second done", got, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_absolute();
    t_direct();
    t_pre_indexed();
    t_post_indexed();
    t_stack();
    t_indirect();
    t_stall_restart();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule